// File: doc/BRIEF.md
# Clock Output Channel Divider

This block is one output lane of a clock distribution tree. It divides its source clock by an integer from 1 to 1024 and produces a near-square output whose high and low times are each exactly N half source periods. The output therefore keeps a 50% duty cycle for odd ratios too, because it uses both edges of the source. After a restart, the divider starts from a programmable position counted in half source periods. Lanes with the same ratio and different offsets therefore hold a fixed skew to one another.

One 24-bit configuration word sets up the lane. It sets the ratio, the start offset, output inversion, power-down, and whether the lane follows the shared synchronization request. It also carries a low-power flag and a 4-bit driver code. The block does not act on those two fields; it only registers them and passes them on to the output driver.

To align a group of lanes, system control raises the shared sync request for a while and then drops it. Every lane that does not ignore sync holds its divider while the request is high. All of them then restart together on the first rising source edge that sees the request low. A channel that is not used is given power-down together with a tri-state driver code.

Top module: `clk_chan_div`

## Requirements
- R1: The ratio field sits at word bits 17:8 and holds N-1, so N runs from 1 to 1024. While running, the output repeats every N source cycles and is high for N half periods and low for N half periods.
- R2: With N = 1 and an even offset the output equals the source clock. With N = 1 and an odd offset it is the source clock inverted.
- R3: The offset field sits at word bits 23:18 (P from 0 to 63). Number the half periods after a restart edge as h = 0, 1, 2, and so on, where h = 0 is the high half that follows the restart edge. The divider level in half h is high exactly when ((P + h) mod 2N) < N.
- R4: When syncReq is sampled high on a rising edge and bit 6 is clear, the divider level is low from that edge onward. The first rising edge that samples syncReq low is a restart edge as defined in R3.
- R5: While word bit 6 is set, syncReq has no effect. The output continues its R3 sequence without any break.
- R6: Word bit 7 inverts the divider level, including the low level held during a sync hold. The bit takes effect from the rising edge that samples it.
- R7: Word bit 5 forces clkOut to a static 0 whatever bit 7 holds, from the rising edge that samples it, and holds the divider. The first rising edge that samples bit 5 clear is a restart edge.
- R8: Word bits 3:0 (driver code) and bit 4 (low-power flag) appear on drvMode and lowPower one rising edge after they are sampled. They have no effect on clkOut.
- R9: While rstN is low, clkOut, drvMode and lowPower are 0. The first rising edge after reset that sees no sync hold and no power-down is a restart edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source clock to be divided; both of its edges are used |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 24 | Lane configuration word |
| syncReq | input | 1 | Shared divider synchronization request, active high |
| clkOut | output | 1 | Divided output clock |
| drvMode | output | 4 | Registered driver mode code |
| lowPower | output | 1 | Registered low-power flag |

## Verification
The main divide function is exercised with an even ratio (4), an odd ratio (5) and the top ratio (1024 with offset 63). Together these separate a correct half-period duty cycle from a full-cycle approximation, and show the counter reaching its full width. Ratio 1 is run with offsets 0 and 1 to show the source clock passed through unchanged and inverted. Ratio 6 is run with offsets 3 and 13; the second is larger than 2N, so it shows whether the start position wraps by the modulus instead of saturating. Sync holds, ignored sync pulses and power-down are each followed through the restart edge, where they differ in whether the count resumes from the offset or continues unbroken.

// File: rtl/clk_chan_div_pkg.sv
package clk_chan_div_pkg;

  // Default field widths of the lane configuration word.
  parameter int DefDrvW   = 4;
  parameter int DefRatioW = 10;
  parameter int DefPhaseW = 6;

  // Strobes from lane control to the divider datapath.
  typedef struct packed {
    logic hold;      // keep the divider parked this edge
    logic restart;   // reload the start position this edge
    logic invert;    // registered output inversion
    logic forceLow;  // registered power-down
  } divStrobe_t;

endpackage

// File: rtl/clk_chan_div_ctrl.sv
module clk_chan_div_ctrl
  import clk_chan_div_pkg::*;
#(
  parameter int DRV_W   = DefDrvW,
  parameter int RATIO_W = DefRatioW,
  parameter int PHASE_W = DefPhaseW,
  localparam int CFG_W  = DRV_W + 4 + RATIO_W + PHASE_W
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic               syncReq,
  output divStrobe_t         strobe,
  output logic [RATIO_W-1:0] ratioM1,
  output logic [PHASE_W-1:0] phaseOfs,
  output logic [DRV_W-1:0]   drvModeQ,
  output logic               lowPowerQ
);

  localparam int LpBit     = DRV_W;
  localparam int PdBit     = DRV_W + 1;
  localparam int IgnBit    = DRV_W + 2;
  localparam int InvBit    = DRV_W + 3;
  localparam int RatioLsb  = DRV_W + 4;
  localparam int PhaseLsb  = RatioLsb + RATIO_W;

  logic pdReq, ignSync, invReq, holdNow;
  logic heldQ, invQ, pdQ, armedQ;

  assign pdReq    = cfgWord[PdBit];
  assign ignSync  = cfgWord[IgnBit];
  assign invReq   = cfgWord[InvBit];
  assign ratioM1  = cfgWord[RatioLsb +: RATIO_W];
  assign phaseOfs = cfgWord[PhaseLsb +: PHASE_W];

  // Park the divider on power-down or on a sync request the lane honours.
  assign holdNow = pdReq | (syncReq & ~ignSync);

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      heldQ     <= 1'b1;
      invQ      <= 1'b0;
      pdQ       <= 1'b0;
      drvModeQ  <= '0;
      lowPowerQ <= 1'b0;
      armedQ    <= 1'b0;
    end else begin
      heldQ     <= holdNow;
      invQ      <= invReq;
      pdQ       <= pdReq;
      drvModeQ  <= cfgWord[DRV_W-1:0];
      lowPowerQ <= cfgWord[LpBit];
      armedQ    <= 1'b1;
    end
  end

  always_comb begin
    strobe.hold     = holdNow;
    strobe.restart  = heldQ & ~holdNow;
    strobe.invert   = invQ;
    strobe.forceLow = pdQ;
  end

  // R8
  drv_follow_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    armedQ |-> (drvModeQ == $past(cfgWord[DRV_W-1:0])) &&
               (lowPowerQ == $past(cfgWord[LpBit])));

  // R5
  ignore_sync_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    (ignSync && !pdReq && !heldQ) |=> !strobe.restart);

endmodule

// File: rtl/clk_chan_div_path.sv
module clk_chan_div_path
  import clk_chan_div_pkg::*;
#(
  parameter int RATIO_W = DefRatioW,
  parameter int PHASE_W = DefPhaseW
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [RATIO_W-1:0] ratioM1,
  input  logic [PHASE_W-1:0] phaseOfs,
  output logic               clkOut
);

  // Position counts half source periods within one output period (0..2N-1).
  localparam int PosW = RATIO_W + 2;
  localparam int RemW = PosW + PHASE_W;

  logic [PosW-1:0] nVal, twoN, startPos, nextPos, midPos, posQ;
  logic            riseQ, fallQ, quietQ, divRaw;

  // Offset reduced modulo the period by restoring subtraction.
  function automatic logic [PosW-1:0] phaseStart(input logic [PHASE_W-1:0] ph,
                                                 input logic [PosW-1:0] period);
    logic [RemW-1:0] rem, step;
    rem = {{PosW{1'b0}}, ph};
    for (int k = PHASE_W - 1; k >= 0; k--) begin
      step = {{PHASE_W{1'b0}}, period} << k;
      if (rem >= step) rem = rem - step;
    end
    return rem[PosW-1:0];
  endfunction

  // Advance by one or two half periods with wrap; clamp after a ratio shrink.
  function automatic logic [PosW-1:0] wrapStep(input logic [PosW-1:0] p,
                                               input logic [1:0] inc,
                                               input logic [PosW-1:0] period);
    logic [PosW:0] sum;
    sum = {1'b0, p} + {{(PosW - 1){1'b0}}, inc};
    if (sum >= {1'b0, period}) sum = sum - {1'b0, period};
    if (sum >= {1'b0, period}) sum = '0;
    return sum[PosW-1:0];
  endfunction

  assign nVal     = {2'b00, ratioM1} + PosW'(1);
  assign twoN     = {nVal[PosW-2:0], 1'b0};
  assign startPos = phaseStart(phaseOfs, twoN);
  assign nextPos  = wrapStep(posQ, 2'd2, twoN);
  assign midPos   = wrapStep(posQ, 2'd1, twoN);

  // Rising edge: position and level of the high half of the source.
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      posQ   <= '0;
      riseQ  <= 1'b0;
      quietQ <= 1'b1;
    end else if (strobe.hold) begin
      posQ   <= startPos;
      riseQ  <= 1'b0;
      quietQ <= 1'b1;
    end else if (strobe.restart) begin
      posQ   <= startPos;
      riseQ  <= (startPos < nVal);
      quietQ <= 1'b0;
    end else begin
      posQ   <= nextPos;
      riseQ  <= (nextPos < nVal);
    end
  end

  // Falling edge: level of the low half of the source.
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) fallQ <= 1'b0;
    else       fallQ <= quietQ ? 1'b0 : (midPos < nVal);
  end

  assign divRaw = srcClk ? riseQ : fallQ;
  assign clkOut = strobe.forceLow ? 1'b0 : (divRaw ^ strobe.invert);

  // R4
  hold_quiet_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    strobe.hold |=> !fallQ && !riseQ);

  // R1
  pos_range_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    $stable(ratioM1) |-> posQ < twoN);

  // R2
  ratio_one_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    (ratioM1 == '0 && $stable(ratioM1) && !quietQ) |-> riseQ != fallQ);

endmodule

// File: rtl/clk_chan_div.sv
module clk_chan_div
  import clk_chan_div_pkg::*;
#(
  parameter int DRV_W   = DefDrvW,
  parameter int RATIO_W = DefRatioW,
  parameter int PHASE_W = DefPhaseW,
  localparam int CFG_W  = DRV_W + 4 + RATIO_W + PHASE_W
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             syncReq,
  output logic             clkOut,
  output logic [DRV_W-1:0] drvMode,
  output logic             lowPower
);

  divStrobe_t         strobe;
  logic [RATIO_W-1:0] ratioM1;
  logic [PHASE_W-1:0] phaseOfs;

  clk_chan_div_ctrl #(
    .DRV_W(DRV_W), .RATIO_W(RATIO_W), .PHASE_W(PHASE_W)
  ) u_ctrl (
    .srcClk(srcClk), .rstN(rstN), .cfgWord(cfgWord), .syncReq(syncReq),
    .strobe(strobe), .ratioM1(ratioM1), .phaseOfs(phaseOfs),
    .drvModeQ(drvMode), .lowPowerQ(lowPower)
  );

  clk_chan_div_path #(
    .RATIO_W(RATIO_W), .PHASE_W(PHASE_W)
  ) u_path (
    .srcClk(srcClk), .rstN(rstN), .strobe(strobe),
    .ratioM1(ratioM1), .phaseOfs(phaseOfs), .clkOut(clkOut)
  );

endmodule

// File: tb/clk_chan_div_bench.sv
module clk_chan_div_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cfgWord = '0;
  logic        syncReq = 1'b0;
  logic        clkOut;
  logic [3:0]  drvMode;
  logic        lowPower;
  int          nChecks = 0;
  int          nFail = 0;

  always #5 clk = ~clk;

  clk_chan_div u_clk_chan_div (
    .srcClk(clk), .rstN(rstN), .cfgWord(cfgWord), .syncReq(syncReq),
    .clkOut(clkOut), .drvMode(drvMode), .lowPower(lowPower)
  );

  function automatic logic [23:0] mkCfg(int n, int p, bit inv, bit ign, bit pd,
                                        bit lp, int drv);
    logic [9:0] r;
    logic [5:0] ph;
    logic [3:0] d;
    r  = 10'(n - 1);
    ph = 6'(p);
    d  = 4'(drv);
    return {ph, r, inv, ign, pd, lp, d};
  endfunction

  function automatic bit expLvl(int n, int p, int h, bit inv);
    return (((p + h) % (2 * n)) < n) ^ inv;
  endfunction

  task automatic chk(logic [3:0] got, logic [3:0] exp, string tag);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkSpan(int n, int p, bit inv, int h0, int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      chk({3'b0, clkOut}, {3'b0, expLvl(n, p, h0 + 2 * i, inv)}, tag);
      @(negedge clk); #2;
      chk({3'b0, clkOut}, {3'b0, expLvl(n, p, h0 + 2 * i + 1, inv)}, tag);
    end
  endtask

  task automatic checkConst(bit v, int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      chk({3'b0, clkOut}, {3'b0, v}, tag);
      @(negedge clk); #2;
      chk({3'b0, clkOut}, {3'b0, v}, tag);
    end
  endtask

  task automatic startRun(logic [23:0] cfg);
    @(negedge clk); #2;
    cfgWord = cfg;
    syncReq = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    syncReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // R9: reset state, then the first free edge restarts the count
  task automatic testReset();
    cfgWord = mkCfg(3, 0, 1, 0, 0, 1, 5);
    repeat (3) @(posedge clk);
    #2 chk({3'b0, clkOut}, 4'd0, "R9 clkOut in reset");
    @(negedge clk); #2;
    chk({3'b0, clkOut}, 4'd0, "R9 clkOut in reset");
    chk(drvMode, 4'd0, "R9 drvMode in reset");
    chk({3'b0, lowPower}, 4'd0, "R9 lowPower in reset");
    rstN = 1'b1;
    checkSpan(3, 0, 1, 0, 4, "R9 restart after reset");
  endtask

  // R1: even, odd and top ratios
  task automatic testRatios();
    startRun(mkCfg(4, 0, 0, 0, 0, 0, 0));
    checkSpan(4, 0, 0, 0, 10, "R1 ratio 4");
    startRun(mkCfg(5, 0, 0, 0, 0, 0, 0));
    checkSpan(5, 0, 0, 0, 12, "R1 ratio 5 odd");
    startRun(mkCfg(1024, 63, 0, 0, 0, 0, 0));
    checkSpan(1024, 63, 0, 0, 1100, "R1 ratio 1024");
  endtask

  // R2: ratio one passes the source clock, or its inverse with an odd offset
  task automatic testRatioOne();
    startRun(mkCfg(1, 0, 0, 0, 0, 0, 0));
    checkSpan(1, 0, 0, 0, 6, "R2 ratio 1 offset 0");
    startRun(mkCfg(1, 1, 0, 0, 0, 0, 0));
    checkSpan(1, 1, 0, 0, 6, "R2 ratio 1 offset 1");
  endtask

  // R3: start offset, including one above the period
  task automatic testPhase();
    startRun(mkCfg(6, 3, 0, 0, 0, 0, 0));
    checkSpan(6, 3, 0, 0, 14, "R3 offset 3");
    startRun(mkCfg(6, 13, 0, 0, 0, 0, 0));
    checkSpan(6, 13, 0, 0, 14, "R3 offset wraps");
  endtask

  // R4 and R6: hold low during sync, inverted hold level, restart
  task automatic testSyncHold();
    startRun(mkCfg(4, 2, 0, 0, 0, 0, 0));
    checkSpan(4, 2, 0, 0, 3, "R4 run before sync");
    syncReq = 1'b1;
    checkConst(1'b0, 3, "R4 held low");
    cfgWord = mkCfg(4, 2, 1, 0, 0, 0, 0);
    checkConst(1'b1, 3, "R6 held level inverted");
    syncReq = 1'b0;
    checkSpan(4, 2, 1, 0, 6, "R6 inverted restart");
  endtask

  // R5: sync pulse ignored while bit 6 is set
  task automatic testIgnore();
    startRun(mkCfg(3, 2, 0, 0, 0, 0, 0));
    checkSpan(3, 2, 0, 0, 4, "R5 before ignore");
    cfgWord = mkCfg(3, 2, 0, 1, 0, 0, 0);
    syncReq = 1'b1;
    checkSpan(3, 2, 0, 8, 4, "R5 sync ignored");
    syncReq = 1'b0;
    checkSpan(3, 2, 0, 16, 3, "R5 after ignored sync");
  endtask

  // R7: power-down static low despite invert, restart on clear
  task automatic testPowerDown();
    startRun(mkCfg(4, 0, 0, 0, 0, 0, 0));
    checkSpan(4, 0, 0, 0, 3, "R7 run before power-down");
    cfgWord = mkCfg(4, 0, 1, 0, 1, 0, 0);
    checkConst(1'b0, 4, "R7 powered down");
    cfgWord = mkCfg(4, 0, 1, 0, 0, 0, 0);
    checkSpan(4, 0, 1, 0, 5, "R7 restart after power-down");
  endtask

  // R8: stored driver fields, no effect on the output
  task automatic testDriverFields();
    startRun(mkCfg(4, 0, 0, 0, 0, 0, 0));
    checkSpan(4, 0, 0, 0, 3, "R8 before field change");
    cfgWord = mkCfg(4, 0, 0, 0, 0, 1, 12);
    checkSpan(4, 0, 0, 6, 3, "R8 output unaffected");
    chk(drvMode, 4'hC, "R8 drvMode");
    chk({3'b0, lowPower}, 4'd1, "R8 lowPower");
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testRatios();
    testRatioOne();
    testPhase();
    testSyncHold();
    testIgnore();
    testPowerDown();
    testDriverFields();
    finishRun();
  end

endmodule